// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that holds a small byte array in internal registers. A master addresses it with a 7-bit device address and a direction bit. In the write direction, the next byte sets the word pointer and the byte after that is the data to store. In the read direction, the slave returns bytes from the word pointer onward.

A write is committed only when a stop follows a complete data byte and its acknowledge. The commit starts an emulated nonvolatile programming window. While that window is open, the device address is not acknowledged, so a master can poll until the slave answers again. The word pointer persists between transactions and always points one past the last byte written or sent. This gives current-address reads, random reads (a write-direction address plus word pointer, then a repeated start in the read direction) and sequential reads.

Both bus inputs pass through two-flop synchronisers. SDA is driven open-drain as a pull-low enable, and that enable only changes after SCL has been seen low.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the slave does not pull SDA, every array byte reads as 0x00, and no programming window is open.
- R2: A device address byte whose upper seven bits differ from `DEV_ADDR` gets no ACK. The slave then stays off SDA until the next start, and a stop always returns the slave to idle with SDA released.
- R3: A write-direction address, a word pointer byte and one data byte are each acknowledged (SDA low during the ninth clock). After the stop, the data is stored at the pointer modulo `DEPTH`.
- R4: A stop that arrives inside the data byte, or before any data byte, leaves the array unchanged and opens no programming window. A word pointer that was already acknowledged is still loaded.
- R5: A committed write keeps the slave busy for `BUSY_CYCLES` clocks from the stop. During that time a device address byte in either direction is not acknowledged. Afterwards it is acknowledged again.
- R6: A random read (write-direction address, word pointer, repeated start, read-direction address) returns the byte stored at that pointer, most significant bit first.
- R7: The word pointer holds the last accessed address plus one, modulo `DEPTH`. A read-direction address without a preceding pointer byte returns data from there and wraps from `DEPTH-1` to 0.
- R8: In a read, an ACK from the master after a byte makes the slave send the byte at the next address.
- R9: A NACK from the master after a read byte makes the slave release SDA and go idle.
- R10: The slave only begins pulling SDA low while SCL is low.
- R11: Data bytes after the first in one write transaction are not acknowledged and are not stored. The first byte is still committed at the stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
The hardest state to reach is the edge of the programming window. A poll must be refused just before the window closes and accepted just after, and this is only visible through whether the ninth clock carries an ACK. The bench starts polling immediately after each committed stop, repeats short address-only transactions, and records the clock count at the first accepted poll. It compares that count against the window length, allowing one poll period of slack. Abort cases are reached by cutting transactions off with a stop after four data bits, and right after the pointer acknowledge. An immediate poll then shows that no window was opened.

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         DEPTH       = 16,
  parameter int         BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [3:0] {
    IDLE, DADDR, DACK, WADDR, WACK, WDATA, WDACK, WHOLD, RDATA, RACK
  } st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;
  logic       scl_s, sda_s;
  assign scl_s = scl_q[1];
  assign sda_s = sda_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_in}; sda_q <= {sda_q[0], sda_in};
      scl_p <= scl_s; sda_p <= sda_s;
    end

  logic start, stop, rise, fall;
  assign start = scl_s & scl_p & sda_p & ~sda_s;
  assign stop  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise  = scl_s & ~scl_p;
  assign fall  = ~scl_s & scl_p;

  st_t         st;
  logic [7:0]  sh, wbuf;
  logic [2:0]  cnt;
  logic        got8, rw, pend, macked;
  logic [AW-1:0] ptr;
  logic [BW-1:0] bcnt;
  logic [7:0]  mem [DEPTH];
  logic        busy;
  assign busy = (bcnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; sh <= '0; wbuf <= '0; cnt <= '0; got8 <= 1'b0; rw <= 1'b0;
      pend <= 1'b0; macked <= 1'b0; ptr <= '0; bcnt <= '0; sda_pull <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (busy) bcnt <= bcnt - 1'b1;
      if (start) begin
        st <= DADDR; cnt <= '0; got8 <= 1'b0; sda_pull <= 1'b0; pend <= 1'b0;
      end else if (stop) begin
        st <= IDLE; sda_pull <= 1'b0; pend <= 1'b0;
        if (pend) begin
          mem[ptr] <= wbuf; ptr <= ptr + 1'b1; bcnt <= BW'(BUSY_CYCLES);
        end
      end else begin
        case (st)
          DADDR, WADDR, WDATA:
            if (rise) begin
              sh <= {sh[6:0], sda_s}; cnt <= cnt + 1'b1;
              if (cnt == 3'd7) got8 <= 1'b1;
            end else if (fall && got8) begin
              got8 <= 1'b0;
              if (st == DADDR) begin
                if (sh[7:1] == DEV_ADDR && !busy) begin
                  sda_pull <= 1'b1; rw <= sh[0]; st <= DACK;
                end else st <= IDLE;
              end else if (st == WADDR) begin
                ptr <= sh[AW-1:0]; sda_pull <= 1'b1; st <= WACK;
              end else begin
                wbuf <= sh; sda_pull <= 1'b1; st <= WDACK;
              end
            end
          DACK:
            if (fall) begin
              cnt <= '0;
              if (rw) begin
                sh <= mem[ptr]; sda_pull <= ~mem[ptr][7]; st <= RDATA;
              end else begin
                sda_pull <= 1'b0; st <= WADDR;
              end
            end
          WACK:
            if (fall) begin sda_pull <= 1'b0; cnt <= '0; st <= WDATA; end
          WDACK:
            if (fall) begin sda_pull <= 1'b0; pend <= 1'b1; st <= WHOLD; end
          RDATA:
            if (fall) begin
              if (cnt == 3'd7) begin
                sda_pull <= 1'b0; ptr <= ptr + 1'b1; st <= RACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_pull <= ~sh[6]; cnt <= cnt + 1'b1;
              end
            end
          RACK:
            if (rise) macked <= ~sda_s;
            else if (fall) begin
              if (macked) begin
                sh <= mem[ptr]; sda_pull <= ~mem[ptr][7]; cnt <= '0; st <= RDATA;
              end else st <= IDLE;
            end
          default: ;
        endcase
      end
    end
endmodule

module serial_mem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       pull,
  input logic [3:0] st,
  input logic       busy,
  input logic       stop,
  input logic       fall,
  input logic       macked
);
  a_r10_pull_after_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> !$past(scl_s));
  a_r5_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st != 4'd2);
  a_r4_window_only_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == 4'd0 && !pull));
  a_r9_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd9 && fall && !macked) |=> (st == 4'd0 && !pull));
  a_r3_quiet_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd5) |-> !pull);
endmodule

bind serial_mem_slave serial_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .pull(sda_pull), .st(st),
  .busy(busy), .stop(stop), .fall(fall), .macked(macked)
);

// File: tb/test_serial_mem_slave.sv
module test_serial_mem_slave;
  localparam logic [6:0] DEV = 7'h50;
  localparam int BUSY = 600;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;
  always #5 clk = ~clk;

  serial_mem_slave #(.DEV_ADDR(DEV), .DEPTH(16), .BUSY_CYCLES(BUSY)) i_serial_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull));

  int total = 0, bad = 0, cyc = 0, t_stop = 0;
  logic [7:0] mem_m [16];
  logic [3:0] ptr_m = 4'd0;
  logic pull_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  // R10: a new pull-low may only begin while SCL is held low
  always @(negedge clk) begin
    if (rst_n && sda_pull && !pull_prev) check(scl_m == 1'b0, "R10", scl_m, 0);
    pull_prev <= sda_pull;
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic put_bit(input bit b);
    scl_m = 0; wt(H); sda_m = b; wt(H); scl_m = 1; wt(H);
  endtask
  task automatic do_start(); scl_m = 0; wt(H); sda_m = 1; wt(H); scl_m = 1; wt(H); sda_m = 0; wt(H); endtask
  task automatic do_stop();  scl_m = 0; wt(H); sda_m = 0; wt(H); scl_m = 1; wt(H); sda_m = 1; wt(H); endtask
  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    scl_m = 0; wt(H); sda_m = 1; wt(H); scl_m = 1; wt(H/2); ack = !sda_line; wt(H/2);
  endtask
  task automatic recv(output logic [7:0] b, input bit ack);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 0; wt(H); sda_m = 1; wt(H); scl_m = 1; wt(H/2); b[i] = sda_line; wt(H/2);
    end
    put_bit(!ack);
  endtask

  task automatic write1(input logic [3:0] a, input logic [7:0] d);
    bit k;
    do_start(); send({DEV, 1'b0}, k); check(k, "R3 dev ack", k, 1);
    send({4'h0, a}, k); check(k, "R3 ptr ack", k, 1);
    send(d, k); check(k, "R3 data ack", k, 1);
    do_stop(); t_stop = cyc; mem_m[a] = d; ptr_m = a + 4'd1;
  endtask

  task automatic poll(input bit expect_busy);
    bit k; int n = 0;
    forever begin
      do_start(); send({DEV, 1'b0}, k);
      if (k) begin
        if (expect_busy) check(cyc - t_stop >= BUSY - H && cyc - t_stop < BUSY + 400,
                               "R5 window length", cyc - t_stop, BUSY);
        do_stop(); break;
      end
      do_stop(); n++;
      if (n > 10) break;
    end
    check(expect_busy ? (n > 0) : (n == 0), expect_busy ? "R5 busy nack" : "R4 no window", n, expect_busy);
  endtask

  task automatic read_bytes(input int n, input string tag);
    logic [7:0] b;
    for (int j = 0; j < n; j++) begin
      recv(b, j < n - 1);
      check(b == mem_m[ptr_m], tag, b, mem_m[ptr_m]);
      ptr_m = ptr_m + 4'd1;
    end
    wt(H); check(sda_pull == 1'b0, "R9 release", sda_pull, 0);
    do_stop();
  endtask

  task automatic rand_read(input logic [3:0] a, input int n, input string tag);
    bit k;
    do_start(); send({DEV, 1'b0}, k); check(k, "R6 dev ack", k, 1);
    send({4'h0, a}, k); check(k, "R6 ptr ack", k, 1); ptr_m = a;
    do_start(); send({DEV, 1'b1}, k); check(k, "R6 read ack", k, 1);
    read_bytes(n, tag);
  endtask

  task automatic cur_read(input int n, input string tag);
    bit k;
    do_start(); send({DEV, 1'b1}, k); check(k, "R7 read ack", k, 1);
    read_bytes(n, tag);
  endtask

  initial begin
    bit k;
    for (int i = 0; i < 16; i++) mem_m[i] = 8'h00;
    wt(5); rst_n = 1; wt(5);
    check(sda_pull == 1'b0, "R1 released", sda_pull, 0);
    rand_read(4'd5, 1, "R1 zero array");
    poll(1'b0);

    write1(4'd3, 8'hA5); poll(1'b1);
    rand_read(4'd3, 1, "R6 data");
    cur_read(1, "R7 next address");

    write1(4'd4, 8'h3C); poll(1'b1);
    write1(4'd5, 8'h77); poll(1'b1);
    write1(4'd15, 8'h11); poll(1'b1);
    write1(4'd0, 8'h5A); poll(1'b1);
    rand_read(4'd3, 3, "R8 sequential");
    cur_read(1, "R7 after sequential");
    rand_read(4'd15, 1, "R6 top");
    cur_read(1, "R7 wrap");

    // R2: foreign address
    do_start(); send({7'h51, 1'b0}, k); check(!k, "R2 foreign nack", k, 0);
    send(8'h00, k); check(!k, "R2 stays silent", k, 0);
    do_stop(); check(sda_pull == 1'b0, "R2 idle after stop", sda_pull, 0);

    // R4: stop inside data byte
    do_start(); send({DEV, 1'b0}, k); send(8'h07, k);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    do_stop(); ptr_m = 4'd7;
    poll(1'b0);
    rand_read(4'd7, 1, "R4 mid-byte abort");
    // R4: stop right after pointer
    do_start(); send({DEV, 1'b0}, k); send(8'h09, k); do_stop(); ptr_m = 4'd9;
    poll(1'b0);
    cur_read(1, "R4 pointer-only");

    // R11: second data byte refused
    do_start(); send({DEV, 1'b0}, k); send(8'h08, k); send(8'hC3, k);
    check(k, "R11 first data ack", k, 1);
    send(8'h99, k); check(!k, "R11 extra nack", k, 0);
    do_stop(); t_stop = cyc; mem_m[8] = 8'hC3; ptr_m = 4'd9;
    poll(1'b1);
    rand_read(4'd8, 2, "R11 stored");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule